// File: doc/BRIEF.md
# Power-on reset sequencer

This block produces the active-low reset line for a small processor board. When power comes up it holds reset for a fixed interval. That interval is counted in rising edges of a slow reference tick, so it does not depend on the main oscillator's frequency. With the default 1 kHz tick, 100 edges give roughly 100 ms for the supply to settle.

Next it counts a fixed number of main-clock periods so that a crystal oscillator has time to stabilise. A short shift-register chain, clocked by the system clock, then hands reset off to the running state. A mode input marks the clock as a fast-starting RC oscillator, and in that case the oscillator count is skipped.

A push-button input is synchronised and debounced against the reference tick. A valid press restarts the whole timed sequence and drops reset immediately. The current phase is visible on a two-bit status output.

Top module: `por_sequencer`

## Requirements
- R1: While `por_n` is low, `rst_n_o` is low and `phase_o` reads 0. The phase codes are 0 = supply wait, 1 = oscillator count, 2 = release chain and 3 = running. Taking `por_n` low at any time forces this state at once.
- R2: After power-up or a restart, the supply-wait phase (code 0) lasts until `WAIT_TICKS` rising edges of `ref_tick` have been seen, and `rst_n_o` stays low throughout.
- R3: With `rc_mode` = 0, the oscillator-count phase (code 1) lasts exactly `OSC_CYCLES` clock cycles.
- R4: If `btn_n` is held low across `DEBOUNCE_TICKS` rising edges of `ref_tick`, the sequence restarts in phase 0 with `rst_n_o` low. This applies whatever the current phase is, and the wait interval is counted anew from the restart.
- R5: The release phase (code 2) lasts exactly `CHAIN_LEN` clock cycles (at least 2). `rst_n_o` goes high in the same cycle that the phase becomes 3, and it is high only in phase 3.
- R6: A press that covers fewer than `DEBOUNCE_TICKS` reference edges has no effect on `rst_n_o` or `phase_o`. A press that is held longer restarts the sequence only once.
- R7: With `rc_mode` = 1, the sequence goes from phase 0 straight to phase 2 and never enters phase 1.
- R8: Once running, `rst_n_o` stays high and the phase stays 3 until a debounced press or `por_n` arrives.
- R9: If a debounced press completes in the same cycle that the supply-wait interval ends, the restart wins. The phase stays 0 and a full new wait interval follows.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock from the main oscillator |
| por_n | input | 1 | Asynchronous power-up indication, active low |
| ref_tick | input | 1 | Slow reference square wave (1 kHz nominal), asynchronous |
| btn_n | input | 1 | Manual reset push-button, active low, asynchronous and bouncy |
| rc_mode | input | 1 | 1 = RC oscillator, skip the oscillator count |
| rst_n_o | output | 1 | System reset, active low |
| phase_o | output | 2 | Current phase: 0 wait, 1 oscillator count, 2 release, 3 running |

## Verification
A debounced button restart and the end of the supply-wait interval both occur on a reference-tick edge, so they can fall in the same clock cycle. The bench provokes this by pulling the button low just before the last four wait ticks. The fourth low tick therefore coincides with the final wait tick. It judges the result by requiring phase 0 right after that tick, and then a full new wait interval followed by an exact 1024-cycle oscillator phase.

// File: rtl/por_seq_pkg.sv
package por_seq_pkg;

    typedef enum logic [1:0] {
        PH_WAIT = 2'd0,
        PH_OSC  = 2'd1,
        PH_REL  = 2'd2,
        PH_RUN  = 2'd3
    } phase_e;

endpackage

// File: rtl/por_sync.sv
module por_sync #(
    parameter int   STAGES = 2,
    parameter logic INIT   = 1'b0
) (
    input  logic clk,
    input  logic arst_n,
    input  logic d,
    output logic q
);

    logic [STAGES-1:0] pipe_d;
    logic [STAGES-1:0] pipe_q;

    always_comb begin
        pipe_d = {pipe_q[STAGES-2:0], d};
    end

    always_ff @(posedge clk or negedge arst_n) begin
        if (!arst_n) pipe_q <= {STAGES{INIT}};
        else         pipe_q <= pipe_d;
    end

    assign q = pipe_q[STAGES-1];

endmodule

// File: rtl/por_debounce.sv
module por_debounce #(
    parameter int TICKS = 4
) (
    input  logic clk,
    input  logic por_n,
    input  logic btn_s,
    input  logic tick,
    output logic fire
);

    localparam int W = $clog2(TICKS + 1);

    typedef struct packed {
        logic [W-1:0] cnt;
        logic         armed;
    } db_s;

    db_s db_d;
    db_s db_q;

    always_comb begin
        db_d = db_q;
        fire = 1'b0;
        if (btn_s) begin
            db_d.cnt   = '0;
            db_d.armed = 1'b1;
        end else if (tick && db_q.armed) begin
            if (db_q.cnt == W'(TICKS - 1)) begin
                fire       = 1'b1;
                db_d.armed = 1'b0;
                db_d.cnt   = '0;
            end else begin
                db_d.cnt = db_q.cnt + 1'b1;
            end
        end
    end

    always_ff @(posedge clk or negedge por_n) begin
        if (!por_n) db_q <= '{cnt: '0, armed: 1'b1};
        else        db_q <= db_d;
    end

    AST_FIRE_ONCE_PER_PRESS: assert property (@(posedge clk) disable iff (!por_n) fire |=> !fire); // R6
    AST_FIRE_ONLY_ON_TICK: assert property (@(posedge clk) disable iff (!por_n) fire |-> (tick && !btn_s)); // R4

endmodule

// File: rtl/por_release_chain.sv
module por_release_chain #(
    parameter int LEN = 3
) (
    input  logic clk,
    input  logic por_n,
    input  logic clear,
    input  logic shift,
    output logic pre_last,
    output logic last
);

    logic [LEN-1:0] chain_d;
    logic [LEN-1:0] chain_q;

    always_comb begin
        chain_d = chain_q;
        if (clear)      chain_d = '0;
        else if (shift) chain_d = {chain_q[LEN-2:0], 1'b1};
    end

    always_ff @(posedge clk or negedge por_n) begin
        if (!por_n) chain_q <= '0;
        else        chain_q <= chain_d;
    end

    assign pre_last = chain_q[LEN-2];
    assign last     = chain_q[LEN-1];

    AST_CLEAR_EMPTIES_CHAIN: assert property (@(posedge clk) disable iff (!por_n) clear |=> !last); // R4
    AST_LAST_AFTER_PREV: assert property (@(posedge clk) disable iff (!por_n) $rose(last) |-> $past(pre_last)); // R5

endmodule

// File: rtl/por_sequencer.sv
module por_sequencer
    import por_seq_pkg::*;
#(
    parameter int WAIT_TICKS     = 100,
    parameter int OSC_CYCLES     = 1024,
    parameter int CHAIN_LEN      = 3,
    parameter int DEBOUNCE_TICKS = 4,
    parameter int SYNC_STAGES    = 2
) (
    input  logic       clk,
    input  logic       por_n,
    input  logic       ref_tick,
    input  logic       btn_n,
    input  logic       rc_mode,
    output logic       rst_n_o,
    output logic [1:0] phase_o
);

    localparam int CNT_MAX = (WAIT_TICKS > OSC_CYCLES) ? WAIT_TICKS : OSC_CYCLES;
    localparam int CNT_W   = $clog2(CNT_MAX + 1);

    typedef struct packed {
        phase_e           phase;
        logic [CNT_W-1:0] cnt;
        logic             ref_prev;
    } seq_s;

    seq_s seq_d;
    seq_s seq_q;

    logic ref_s;
    logic btn_s;
    logic tick;
    logic restart;
    logic chain_clear;
    logic chain_shift;
    logic chain_pre;
    logic chain_last;

    por_sync #(.STAGES(SYNC_STAGES), .INIT(1'b0)) u_ref_sync (
        .clk    (clk),
        .arst_n (por_n),
        .d      (ref_tick),
        .q      (ref_s)
    );

    por_sync #(.STAGES(SYNC_STAGES), .INIT(1'b1)) u_btn_sync (
        .clk    (clk),
        .arst_n (por_n),
        .d      (btn_n),
        .q      (btn_s)
    );

    assign tick = ref_s & ~seq_q.ref_prev;

    por_debounce #(.TICKS(DEBOUNCE_TICKS)) u_debounce (
        .clk   (clk),
        .por_n (por_n),
        .btn_s (btn_s),
        .tick  (tick),
        .fire  (restart)
    );

    always_comb begin
        seq_d          = seq_q;
        seq_d.ref_prev = ref_s;
        case (seq_q.phase)
            PH_WAIT: begin
                if (tick) begin
                    if (seq_q.cnt == CNT_W'(WAIT_TICKS - 1)) begin
                        seq_d.cnt   = '0;
                        seq_d.phase = rc_mode ? PH_REL : PH_OSC;
                    end else begin
                        seq_d.cnt = seq_q.cnt + 1'b1;
                    end
                end
            end
            PH_OSC: begin
                if (seq_q.cnt == CNT_W'(OSC_CYCLES - 1)) begin
                    seq_d.cnt   = '0;
                    seq_d.phase = PH_REL;
                end else begin
                    seq_d.cnt = seq_q.cnt + 1'b1;
                end
            end
            PH_REL: begin
                if (chain_pre) seq_d.phase = PH_RUN;
            end
            PH_RUN: begin
                seq_d.phase = PH_RUN;
            end
            default: seq_d.phase = PH_WAIT;
        endcase
        if (restart) begin
            seq_d.phase = PH_WAIT;
            seq_d.cnt   = '0;
        end
    end

    always_ff @(posedge clk or negedge por_n) begin
        if (!por_n) seq_q <= '{phase: PH_WAIT, cnt: '0, ref_prev: 1'b0};
        else        seq_q <= seq_d;
    end

    assign chain_clear = restart | (seq_q.phase == PH_WAIT) | (seq_q.phase == PH_OSC);
    assign chain_shift = (seq_q.phase == PH_REL) | (seq_q.phase == PH_RUN);

    por_release_chain #(.LEN(CHAIN_LEN)) u_chain (
        .clk      (clk),
        .por_n    (por_n),
        .clear    (chain_clear),
        .shift    (chain_shift),
        .pre_last (chain_pre),
        .last     (chain_last)
    );

    assign rst_n_o = chain_last;
    assign phase_o = seq_q.phase;

    AST_RST_ONLY_RUNNING: assert property (@(posedge clk) disable iff (!por_n) rst_n_o == (seq_q.phase == PH_RUN)); // R5
    AST_RESTART_TO_WAIT: assert property (@(posedge clk) disable iff (!por_n) restart |=> (seq_q.phase == PH_WAIT && !rst_n_o)); // R4
    AST_RC_SKIPS_OSC: assert property (@(posedge clk) disable iff (!por_n) (seq_q.phase == PH_WAIT && rc_mode) |=> seq_q.phase != PH_OSC); // R7
    AST_RUN_HOLDS: assert property (@(posedge clk) disable iff (!por_n) (seq_q.phase == PH_RUN && !restart) |=> seq_q.phase == PH_RUN); // R8
    AST_OSC_CNT_BOUND: assert property (@(posedge clk) disable iff (!por_n) seq_q.phase == PH_OSC |-> seq_q.cnt < CNT_W'(OSC_CYCLES)); // R3
    AST_WAIT_CNT_BOUND: assert property (@(posedge clk) disable iff (!por_n) seq_q.phase == PH_WAIT |-> seq_q.cnt < CNT_W'(WAIT_TICKS)); // R2

endmodule

// File: tb/por_sequencer_test.sv
module por_sequencer_test;

    localparam int WAIT_T  = 100;
    localparam int OSC_C   = 1024;
    localparam int CHAIN_L = 3;
    localparam int DEB_T   = 4;
    localparam int NVEC    = 4;
    // each row: press length in reference ticks, rc_mode during the following sequence
    localparam int VEC [NVEC][2] = '{'{2, 0}, '{3, 0}, '{4, 0}, '{6, 1}};

    logic       clk = 1'b0;
    logic       por_n;
    logic       ref_tick;
    logic       btn_n;
    logic       rc_mode;
    logic       rst_n_o;
    logic [1:0] phase_o;

    int checks = 0;
    int errors = 0;
    int cycles = 0;
    int osc_n;
    int rel_n;

    always #5 clk = ~clk;

    por_sequencer uut (
        .clk      (clk),
        .por_n    (por_n),
        .ref_tick (ref_tick),
        .btn_n    (btn_n),
        .rc_mode  (rc_mode),
        .rst_n_o  (rst_n_o),
        .phase_o  (phase_o)
    );

    task automatic chk(input string req, input string what, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
        end
    endtask

    task automatic tick();
        ref_tick = 1'b1;
        repeat (4) @(negedge clk);
        ref_tick = 1'b0;
        repeat (4) @(negedge clk);
    endtask

    // final wait tick, then count cycles in phases 1 and 2 until reset releases
    task automatic finish_seq(output int o_n, output int r_n);
        o_n = 0;
        r_n = 0;
        ref_tick = 1'b1;
        for (int i = 0; i < 3000; i++) begin
            @(negedge clk);
            if (i == 3) ref_tick = 1'b0;
            if (phase_o == 2'd1) o_n++;
            if (phase_o == 2'd2) r_n++;
            if (rst_n_o) break;
        end
        ref_tick = 1'b0;
        repeat (4) @(negedge clk);
    endtask

    always @(posedge clk) begin
        cycles++;
        if (cycles > 150000) begin
            checks++;
            errors++;
            $display("FAIL watchdog: actual %0d expected below 150000", cycles);
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        por_n = 1'b0; ref_tick = 1'b0; btn_n = 1'b1; rc_mode = 1'b0;
        repeat (5) @(negedge clk);
        chk("R1", "rst_n under por", int'(rst_n_o), 0);
        chk("R1", "phase under por", int'(phase_o), 0);
        por_n = 1'b1;

        repeat (WAIT_T - 1) tick();
        chk("R2", "phase before last wait tick", int'(phase_o), 0);
        chk("R2", "rst_n during wait", int'(rst_n_o), 0);
        finish_seq(osc_n, rel_n);
        chk("R3", "oscillator phase cycles", osc_n, OSC_C);
        chk("R5", "release phase cycles", rel_n, CHAIN_L);
        chk("R5", "rst_n after release", int'(rst_n_o), 1);
        repeat (5) tick();
        chk("R8", "phase while running", int'(phase_o), 3);
        chk("R8", "rst_n while running", int'(rst_n_o), 1);

        for (int v = 0; v < NVEC; v++) begin
            rc_mode = VEC[v][1][0];
            btn_n = 1'b0;
            repeat (VEC[v][0]) tick();
            btn_n = 1'b1;
            repeat (3) @(negedge clk);
            if (VEC[v][0] >= DEB_T) begin
                chk("R4", "phase after valid press", int'(phase_o), 0);
                chk("R4", "rst_n after valid press", int'(rst_n_o), 0);
                repeat (WAIT_T - 1 - (VEC[v][0] - DEB_T)) tick();
                chk("R4", "phase before wait ends", int'(phase_o), 0);
                finish_seq(osc_n, rel_n);
                if (VEC[v][1] != 0) chk("R7", "rc mode oscillator cycles", osc_n, 0);
                else                chk("R3", "oscillator cycles after restart", osc_n, OSC_C);
                chk("R5", "release cycles after restart", rel_n, CHAIN_L);
                chk("R5", "rst_n after restart release", int'(rst_n_o), 1);
            end else begin
                chk("R6", "rst_n after short press", int'(rst_n_o), 1);
                chk("R6", "phase after short press", int'(phase_o), 3);
            end
        end
        rc_mode = 1'b0;

        // restart while in the oscillator phase
        btn_n = 1'b0; repeat (DEB_T) tick(); btn_n = 1'b1;
        repeat (WAIT_T - 1) tick();
        tick();
        chk("R4", "phase entered oscillator count", int'(phase_o), 1);
        btn_n = 1'b0; repeat (DEB_T) tick(); btn_n = 1'b1;
        repeat (2) @(negedge clk);
        chk("R4", "phase after press in oscillator count", int'(phase_o), 0);
        chk("R4", "rst_n after press in oscillator count", int'(rst_n_o), 0);

        // restart coinciding with the end of the wait interval
        repeat (WAIT_T - DEB_T) tick();
        btn_n = 1'b0;
        repeat (DEB_T) tick();
        chk("R9", "phase after coincident restart", int'(phase_o), 0);
        chk("R9", "rst_n after coincident restart", int'(rst_n_o), 0);
        btn_n = 1'b1;
        repeat (WAIT_T - 1) tick();
        chk("R9", "phase before new wait ends", int'(phase_o), 0);
        finish_seq(osc_n, rel_n);
        chk("R9", "oscillator cycles after coincidence", osc_n, OSC_C);
        chk("R9", "rst_n after coincidence", int'(rst_n_o), 1);

        // power indication dropping while running
        por_n = 1'b0;
        #1;
        chk("R1", "rst_n at por while running", int'(rst_n_o), 0);
        chk("R1", "phase at por while running", int'(phase_o), 0);
        @(negedge clk);
        por_n = 1'b1;
        repeat (4) @(negedge clk);

        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule